// File: doc/BRIEF.md
# Register Alias Map Table

This block keeps, for every architectural register, the tag of the reservation station that will write the register's next value, together with the register file that holds committed values. A tag of zero says the register file already holds the current value; any other tag names the station still computing it. The dispatch side presents two source register numbers and may rename one destination register per cycle. For each source the block answers combinationally with either a ready flag and the value, or the pending tag.

The writeback side takes one result broadcast per cycle: a tag, a value and the destination register. The broadcast clears the mapping and writes the register file only when the mapping still names that tag. A register that has been renamed again since that producer dispatched keeps its newer tag, and its register-file copy is left alone. Source lookups also take a broadcast in the same cycle into account, so a consumer never misses a result that completes while it dispatches.

Top module: `reg_alias_map`

## Requirements
- R1: Reset sets every tag entry and every register-file word to zero, so every source lookup then returns ready with value zero.
- R2: A source whose entry is zero returns ready=1, tag output zero, and the register-file value. Lookups see the table as it stood before any rename in the same cycle.
- R3: A source whose entry is nonzero and not on the broadcast returns ready=0, the stored tag, and value zero.
- R4: When `rn_en` is high, the destination entry takes `rn_tag` at the next clock edge, whatever tag it held. There is no stall on an existing mapping.
- R5: A broadcast whose tag equals the destination's entry clears that entry to zero and writes the value into the register file.
- R6: A broadcast whose tag differs from the destination's entry leaves both the entry and the register-file word unchanged.
- R7: When a rename and a matching broadcast hit the same register in one cycle, the entry holds the new rename tag afterwards.
- R8: A source whose nonzero entry equals the broadcast tag in the same cycle returns ready=1 with the broadcast value.
- R9: A broadcast carrying tag zero has no effect on the table or the register file. Rename tags are always nonzero.
- R10: The two source ports are independent, and both may name the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_a | input | AW | First source register number |
| src_b | input | AW | Second source register number |
| rn_en | input | 1 | Rename the destination this cycle |
| rn_reg | input | AW | Destination register to rename |
| rn_tag | input | TAG_W | Station tag of the new producer (nonzero) |
| wb_en | input | 1 | Result broadcast valid |
| wb_tag | input | TAG_W | Tag of the completing station |
| wb_dst | input | AW | Destination register of the result |
| wb_val | input | DATA_W | Result value |
| src_a_rdy | output | 1 | First source value available |
| src_a_tag | output | TAG_W | Pending tag for first source (zero when ready) |
| src_a_val | output | DATA_W | First source value (zero when not ready) |
| src_b_rdy | output | 1 | Second source value available |
| src_b_tag | output | TAG_W | Pending tag for second source (zero when ready) |
| src_b_val | output | DATA_W | Second source value (zero when not ready) |

## Verification
The bench builds the block with eight registers, three-bit tags and 16-bit data. With these values every tag value and every register number fit in a short table, so a single run can reach tag reuse across registers, a doubly renamed register and the highest and lowest register numbers. The small sizes also allow a stale broadcast against a zero entry and a same-cycle rename and clear, each observed through the source lookup ports.

// File: rtl/reg_alias_map.sv
module reg_alias_map #(
  parameter int NREG   = 32,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     src_a,
  input  logic [AW-1:0]     src_b,
  input  logic              rn_en,
  input  logic [AW-1:0]     rn_reg,
  input  logic [TAG_W-1:0]  rn_tag,
  input  logic              wb_en,
  input  logic [TAG_W-1:0]  wb_tag,
  input  logic [AW-1:0]     wb_dst,
  input  logic [DATA_W-1:0] wb_val,
  output logic              src_a_rdy,
  output logic [TAG_W-1:0]  src_a_tag,
  output logic [DATA_W-1:0] src_a_val,
  output logic              src_b_rdy,
  output logic [TAG_W-1:0]  src_b_tag,
  output logic [DATA_W-1:0] src_b_val
);

  logic [TAG_W-1:0]  map [NREG];
  logic [DATA_W-1:0] rf  [NREG];

  logic              bc_live;
  logic              wb_match;
  logic [TAG_W-1:0]  ent_a, ent_b;
  logic              hit_a, hit_b;

  assign bc_live  = wb_en && (wb_tag != '0);
  assign wb_match = bc_live && (map[wb_dst] == wb_tag);

  assign ent_a = map[src_a];
  assign ent_b = map[src_b];
  assign hit_a = bc_live && (ent_a == wb_tag);
  assign hit_b = bc_live && (ent_b == wb_tag);

  assign src_a_rdy = (ent_a == '0) || hit_a;
  assign src_a_tag = src_a_rdy ? '0 : ent_a;
  assign src_a_val = (ent_a == '0) ? rf[src_a] : (hit_a ? wb_val : '0);

  assign src_b_rdy = (ent_b == '0) || hit_b;
  assign src_b_tag = src_b_rdy ? '0 : ent_b;
  assign src_b_val = (ent_b == '0) ? rf[src_b] : (hit_b ? wb_val : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        map[i] <= '0;
        rf[i]  <= '0;
      end
    end else begin
      if (wb_match) begin
        rf[wb_dst]  <= wb_val;
        map[wb_dst] <= '0;
      end
      if (rn_en)
        map[rn_reg] <= rn_tag;
    end
  end

  a_r4_rename_lands: assert property (@(posedge clk) disable iff (!rst_n)
    rn_en |=> map[$past(rn_reg)] == $past(rn_tag));

  a_r5_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && wb_tag != '0 && map[wb_dst] == wb_tag && !(rn_en && rn_reg == wb_dst))
      |=> (map[$past(wb_dst)] == '0) && (rf[$past(wb_dst)] == $past(wb_val)));

  a_r6_stale_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && map[wb_dst] != wb_tag && !(rn_en && rn_reg == wb_dst))
      |=> (map[$past(wb_dst)] == $past(map[wb_dst])) && (rf[$past(wb_dst)] == $past(rf[wb_dst])));

  a_r9_rename_tag_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    rn_en |-> rn_tag != '0);

  a_r3_pending_has_tag: assert property (@(posedge clk) disable iff (!rst_n)
    !src_a_rdy |-> (src_a_tag != '0) && (src_a_val == '0));

endmodule

// File: tb/sim_reg_alias_map.sv
module sim_reg_alias_map;
  localparam int NR = 8, TW = 3, DW = 16, AW = 3;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] src_a = 0, src_b = 0, rn_reg = 0, wb_dst = 0;
  logic rn_en = 0, wb_en = 0;
  logic [TW-1:0] rn_tag = 0, wb_tag = 0;
  logic [DW-1:0] wb_val = 0;
  logic a_rdy, b_rdy;
  logic [TW-1:0] a_tag, b_tag;
  logic [DW-1:0] a_val, b_val;

  always #10 clk = ~clk;

  reg_alias_map #(.NREG(NR), .TAG_W(TW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
    .rn_en(rn_en), .rn_reg(rn_reg), .rn_tag(rn_tag),
    .wb_en(wb_en), .wb_tag(wb_tag), .wb_dst(wb_dst), .wb_val(wb_val),
    .src_a_rdy(a_rdy), .src_a_tag(a_tag), .src_a_val(a_val),
    .src_b_rdy(b_rdy), .src_b_tag(b_tag), .src_b_val(b_val));

  typedef struct packed {
    logic [3:0] rq;
    logic rn; logic [2:0] rr; logic [2:0] rt;
    logic wb; logic [2:0] wt; logic [2:0] wd; logic [15:0] wv;
    logic [2:0] sa; logic [2:0] sb;
    logic ar; logic [2:0] at; logic [15:0] av;
    logic br; logic [2:0] bt; logic [15:0] bv;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VT [NV] = '{
    '{4'd1, 1'b0,3'd0,3'd0, 1'b0,3'd0,3'd0,16'h0000, 3'd0,3'd7, 1'b1,3'd0,16'h0000, 1'b1,3'd0,16'h0000}, // R1
    '{4'd2, 1'b1,3'd1,3'd2, 1'b0,3'd0,3'd0,16'h0000, 3'd1,3'd1, 1'b1,3'd0,16'h0000, 1'b1,3'd0,16'h0000}, // R2 R10
    '{4'd3, 1'b0,3'd0,3'd0, 1'b0,3'd0,3'd0,16'h0000, 3'd1,3'd2, 1'b0,3'd2,16'h0000, 1'b1,3'd0,16'h0000}, // R3
    '{4'd4, 1'b1,3'd1,3'd5, 1'b0,3'd0,3'd0,16'h0000, 3'd1,3'd1, 1'b0,3'd2,16'h0000, 1'b0,3'd2,16'h0000}, // R4
    '{4'd6, 1'b0,3'd0,3'd0, 1'b1,3'd2,3'd1,16'h1111, 3'd1,3'd2, 1'b0,3'd5,16'h0000, 1'b1,3'd0,16'h0000}, // R6
    '{4'd6, 1'b0,3'd0,3'd0, 1'b0,3'd0,3'd0,16'h0000, 3'd1,3'd1, 1'b0,3'd5,16'h0000, 1'b0,3'd5,16'h0000}, // R6
    '{4'd8, 1'b0,3'd0,3'd0, 1'b1,3'd5,3'd1,16'h5555, 3'd1,3'd0, 1'b1,3'd0,16'h5555, 1'b1,3'd0,16'h0000}, // R8
    '{4'd5, 1'b0,3'd0,3'd0, 1'b0,3'd0,3'd0,16'h0000, 3'd1,3'd1, 1'b1,3'd0,16'h5555, 1'b1,3'd0,16'h5555}, // R5
    '{4'd2, 1'b1,3'd3,3'd4, 1'b0,3'd0,3'd0,16'h0000, 3'd3,3'd1, 1'b1,3'd0,16'h0000, 1'b1,3'd0,16'h5555}, // R2
    '{4'd7, 1'b1,3'd3,3'd6, 1'b1,3'd4,3'd3,16'h3333, 3'd3,3'd2, 1'b1,3'd0,16'h3333, 1'b1,3'd0,16'h0000}, // R7
    '{4'd7, 1'b0,3'd0,3'd0, 1'b0,3'd0,3'd0,16'h0000, 3'd3,3'd3, 1'b0,3'd6,16'h0000, 1'b0,3'd6,16'h0000}, // R7
    '{4'd8, 1'b0,3'd0,3'd0, 1'b1,3'd6,3'd3,16'h6666, 3'd1,3'd3, 1'b1,3'd0,16'h5555, 1'b1,3'd0,16'h6666}, // R8
    '{4'd5, 1'b0,3'd0,3'd0, 1'b0,3'd0,3'd0,16'h0000, 3'd3,3'd1, 1'b1,3'd0,16'h6666, 1'b1,3'd0,16'h5555}, // R5
    '{4'd9, 1'b0,3'd0,3'd0, 1'b1,3'd0,3'd2,16'hBEEF, 3'd2,3'd2, 1'b1,3'd0,16'h0000, 1'b1,3'd0,16'h0000}, // R9
    '{4'd9, 1'b0,3'd0,3'd0, 1'b0,3'd0,3'd0,16'h0000, 3'd2,3'd3, 1'b1,3'd0,16'h0000, 1'b1,3'd0,16'h6666}, // R9
    '{4'd6, 1'b0,3'd0,3'd0, 1'b1,3'd7,3'd4,16'hAAAA, 3'd4,3'd4, 1'b1,3'd0,16'h0000, 1'b1,3'd0,16'h0000}, // R6
    '{4'd6, 1'b0,3'd0,3'd0, 1'b0,3'd0,3'd0,16'h0000, 3'd4,3'd0, 1'b1,3'd0,16'h0000, 1'b1,3'd0,16'h0000}, // R6
    '{4'd4, 1'b1,3'd7,3'd1, 1'b0,3'd0,3'd0,16'h0000, 3'd7,3'd0, 1'b1,3'd0,16'h0000, 1'b1,3'd0,16'h0000}, // R4
    '{4'd4, 1'b1,3'd0,3'd3, 1'b0,3'd0,3'd0,16'h0000, 3'd7,3'd0, 1'b0,3'd1,16'h0000, 1'b1,3'd0,16'h0000}, // R4
    '{4'd10,1'b0,3'd0,3'd0, 1'b0,3'd0,3'd0,16'h0000, 3'd7,3'd0, 1'b0,3'd1,16'h0000, 1'b0,3'd3,16'h0000}, // R10
    '{4'd8, 1'b0,3'd0,3'd0, 1'b1,3'd1,3'd7,16'h7777, 3'd7,3'd0, 1'b1,3'd0,16'h7777, 1'b0,3'd3,16'h0000}, // R8
    '{4'd8, 1'b0,3'd0,3'd0, 1'b1,3'd3,3'd0,16'h0123, 3'd7,3'd0, 1'b1,3'd0,16'h7777, 1'b1,3'd0,16'h0123}, // R8
    '{4'd10,1'b0,3'd0,3'd0, 1'b0,3'd0,3'd0,16'h0000, 3'd0,3'd0, 1'b1,3'd0,16'h0123, 1'b1,3'd0,16'h0123}  // R10
  };

  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic check(input int rq, input logic er_a, input logic [TW-1:0] et_a,
                       input logic [DW-1:0] ev_a, input logic er_b,
                       input logic [TW-1:0] et_b, input logic [DW-1:0] ev_b);
    nchk++;
    if ({a_rdy, a_tag, a_val, b_rdy, b_tag, b_val} !== {er_a, et_a, ev_a, er_b, et_b, ev_b}) begin
      nfail++;
      $display("FAIL R%0d: got a=%b/%0d/%h b=%b/%0d/%h expected a=%b/%0d/%h b=%b/%0d/%h",
               rq, a_rdy, a_tag, a_val, b_rdy, b_tag, b_val,
               er_a, et_a, ev_a, er_b, et_b, ev_b);
    end
  endtask

  task automatic idle_inputs();
    rn_en = 0; wb_en = 0; rn_reg = 0; rn_tag = 0; wb_tag = 0; wb_dst = 0; wb_val = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      rn_en = VT[i].rn; rn_reg = VT[i].rr; rn_tag = VT[i].rt;
      wb_en = VT[i].wb; wb_tag = VT[i].wt; wb_dst = VT[i].wd; wb_val = VT[i].wv;
      src_a = VT[i].sa; src_b = VT[i].sb;
      #2;
      check(VT[i].rq, VT[i].ar, VT[i].at, VT[i].av, VT[i].br, VT[i].bt, VT[i].bv);
    end
    // R1: reset while registers hold values and pending tags
    @(negedge clk);
    idle_inputs();
    rn_en = 1; rn_reg = 3'd5; rn_tag = 3'd2;
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    src_a = 3'd1; src_b = 3'd3; #2;
    check(1, 1'b1, 3'd0, 16'h0, 1'b1, 3'd0, 16'h0);
    src_a = 3'd5; src_b = 3'd0; #2;
    check(1, 1'b1, 3'd0, 16'h0, 1'b1, 3'd0, 16'h0);
    // R7: same-cycle rename and matching clear on register 6
    @(negedge clk);
    rn_en = 1; rn_reg = 3'd6; rn_tag = 3'd3;
    @(negedge clk);
    rn_en = 1; rn_reg = 3'd6; rn_tag = 3'd7;
    wb_en = 1; wb_tag = 3'd3; wb_dst = 3'd6; wb_val = 16'h4242;
    @(negedge clk);
    idle_inputs();
    src_a = 3'd6; src_b = 3'd6; #2;
    check(7, 1'b0, 3'd7, 16'h0, 1'b0, 3'd7, 16'h0);
    // R5: the newer producer then completes
    @(negedge clk);
    wb_en = 1; wb_tag = 3'd7; wb_dst = 3'd6; wb_val = 16'h9999;
    @(negedge clk);
    idle_inputs(); #2;
    check(5, 1'b1, 3'd0, 16'h9999, 1'b1, 3'd0, 16'h9999);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule